// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block connects a synchronous host request port to an asynchronous DRAM with extended data out and multiplexed address pins. Each host request carries a 21-bit word address, a write flag and one byte of write data. The controller splits the address into a row part and a column part. It places the row on the address pins when RAS falls and the column when CAS falls. It drives RAS, CAS, the write strobe and the output enable from registers, and it returns read bytes on a one-cycle valid pulse.

The row stays open while later requests target the same row. Each such request then costs only one column access. The controller closes the row when a request targets another row, when a refresh is requested, or when the row has been open long enough to approach the maximum RAS-low time. Read data is sampled after CAS has risen again, which is possible because the DRAM keeps its output driven through CAS precharge. All DRAM timing limits are parameters counted in controller clock cycles.

A separate refresh scheduler raises a request. At the next request boundary the controller closes any open row, grants the DRAM to the scheduler and holds off the host until the request is withdrawn.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row is the upper ROW_BITS bits of the request address (default 12, bits 20..9) and is on dram_addr when dram_ras_n falls. The column is the remaining lower bits (default bits 8..0), zero-extended, and is on dram_addr when dram_cas_n falls.
- R2: While reset is held, and after it, all four strobes are high, dram_dq_oe is 0, and req_ready, rd_valid and ref_gnt are 0.
- R3: For a write, dram_we_n goes low and dram_dq_oe goes high with the write byte at least one cycle before dram_cas_n falls, and both hold while CAS is low. A later read of that address returns the byte.
- R4: For a read, dram_we_n stays high and dram_oe_n is low while CAS is low. The byte is sampled after CAS rises and is returned as a one-cycle rd_valid pulse. Bytes are returned in request order.
- R5: Consecutive requests to the open row are served with no new RAS activation.
- R6: A request to a row other than the open one raises RAS, waits out precharge, and activates the new row.
- R7: RAS stays high at least T_RP cycles between activations, stays low at least T_RAS_MIN cycles, and two RAS falls are at least T_RC cycles apart.
- R8: RAS is never low for more than T_RASP cycles. The row is closed before that limit even when same-row requests keep arriving.
- R9: CAS falls only while RAS is low and at least T_RCD cycles after RAS fell. CAS stays low at least T_CAS cycles and high at least T_CP cycles between column accesses.
- R10: A refresh request closes the open row at the next request boundary and then raises ref_gnt. While ref_gnt is high, RAS and CAS are high and no host request is accepted. ref_gnt drops after the request is withdrawn.
- R11: Read data is never sampled earlier than T_RAC cycles after the RAS fall of its row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | DATA_W | Read byte |
| ref_req | input | 1 | Refresh scheduler wants the DRAM |
| ref_gnt | output | 1 | DRAM handed to the refresh scheduler |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | PIN_W | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Byte driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Byte returned by the DRAM |

## Verification
The hardest case to reach is the forced close on the maximum RAS-low limit. At realistic timings a row has to stay open for thousands of cycles with hits arriving back to back. The bench therefore builds the controller with a 40-cycle limit and streams thirty same-row reads without gaps. It then expects more than one activation and a longest RAS-low run within the limit. Refresh pre-emption is reached by raising the refresh request while a row sits open and a host request is held waiting.

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int ROW_BITS  = 12,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 5,
  parameter int T_RAS_MIN = 8,
  parameter int T_RC      = 14,
  parameter int T_RAC     = 8,
  parameter int T_RASP    = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [((ROW_BITS > ADDR_W-ROW_BITS) ? ROW_BITS : ADDR_W-ROW_BITS)-1:0] dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  localparam int COL_BITS = ADDR_W - ROW_BITS;
  localparam int PIN_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int RCW      = $clog2(T_RASP + T_RC + 4);
  localparam int TMW      = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_RAC + 4);
  localparam int RASP_LIM = T_RASP - T_CAS - T_CP - 1;

  typedef enum logic [2:0] {S_IDLE, S_REF, S_ACT, S_CSET, S_CLO, S_CHI, S_OPEN} st_t;

  st_t                st;
  logic [TMW-1:0]     tmr;
  logic [RCW-1:0]     ras_cnt;
  logic [ROW_BITS-1:0] open_row;
  logic               rd_cyc;

  wire [ROW_BITS-1:0] req_row = req_addr[ADDR_W-1 -: ROW_BITS];
  wire [COL_BITS-1:0] req_col = req_addr[COL_BITS-1:0];

  wire row_hit    = req_valid && (req_row == open_row);
  wire rasp_ok    = int'(ras_cnt) < RASP_LIM;
  wire page_go    = row_hit && !ref_req && rasp_ok;
  wire want_close = ref_req || (req_valid && !row_hit) || !rasp_ok;
  wire ras_min_ok = int'(ras_cnt) >= T_RAS_MIN - 1;
  wire act_ok     = (int'(tmr) >= T_RP - 1) && (int'(ras_cnt) >= T_RC - 1);
  wire act_end    = (st == S_ACT) && (int'(tmr) >= T_RCD - 1);
  wire clo_end    = (st == S_CLO) && (int'(tmr) >= T_CAS - 1) && (int'(ras_cnt) >= T_RAC - 2);
  wire chi_end    = (st == S_CHI) && (int'(tmr) >= T_CP - 1);
  wire boundary   = (st == S_OPEN) || chi_end;
  wire col_go     = (act_end && row_hit) || (boundary && page_go);
  wire close_go   = boundary && !page_go && want_close && ras_min_ok;

  assign req_ready = col_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tmr         <= '1;
      ras_cnt     <= '1;
      open_row    <= '0;
      rd_cyc      <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_gnt     <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (ras_cnt != {RCW{1'b1}}) ras_cnt <= ras_cnt + 1'b1;
      if (tmr != {TMW{1'b1}}) tmr <= tmr + 1'b1;

      case (st)
        S_IDLE: if (act_ok) begin
          if (ref_req) begin
            st      <= S_REF;
            ref_gnt <= 1'b1;
          end else if (req_valid) begin
            st         <= S_ACT;
            tmr        <= '0;
            ras_cnt    <= '0;
            dram_ras_n <= 1'b0;
            dram_addr  <= PIN_W'(req_row);
            open_row   <= req_row;
          end
        end
        S_REF: if (!ref_req) begin
          st      <= S_IDLE;
          ref_gnt <= 1'b0;
          tmr     <= '0;
        end
        S_ACT: if (act_end) begin
          st  <= S_OPEN;
          tmr <= '0;
        end
        S_CSET: begin
          st         <= S_CLO;
          tmr        <= '0;
          dram_cas_n <= 1'b0;
        end
        S_CLO: if (clo_end) begin
          st         <= S_CHI;
          tmr        <= '0;
          dram_cas_n <= 1'b1;
        end
        S_CHI: begin
          if (tmr == '0 && rd_cyc) begin
            rd_valid <= 1'b1;
            rd_data  <= dram_dq_in;
          end
          if (chi_end) begin
            st         <= S_OPEN;
            tmr        <= '0;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
          end
        end
        default: ;
      endcase

      if (close_go) begin
        st         <= S_IDLE;
        tmr        <= '0;
        dram_ras_n <= 1'b1;
      end

      if (col_go) begin
        st          <= S_CSET;
        tmr         <= '0;
        dram_addr   <= PIN_W'(req_col);
        dram_we_n   <= !req_we;
        dram_oe_n   <= req_we;
        dram_dq_oe  <= req_we;
        dram_dq_out <= req_wdata;
        rd_cyc      <= !req_we;
      end
    end
  end
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 5,
  parameter int T_RAS_MIN = 8,
  parameter int T_RASP    = 12500
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready,
  input logic ref_gnt,
  input logic rd_valid
);
  int lo_cnt, hi_cnt, cas_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= T_RP;
      cas_lo <= 0;
    end else begin
      lo_cnt <= ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= !ras_n ? 0 : (hi_cnt < 1000000 ? hi_cnt + 1 : hi_cnt);
      cas_lo <= cas_n ? 0 : cas_lo + 1;
    end
  end

  a_r9_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r9_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(lo_cnt) >= T_RCD - 1);
  a_r9_cas_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $past(cas_lo) >= T_CAS - 1);
  a_r7_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(lo_cnt) >= T_RAS_MIN - 1);
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(hi_cnt) >= T_RP - 1);
  a_r8_rasp: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_cnt < T_RASP);
  a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> ($past(!we_n) && dq_oe));
  a_r4_read_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && we_n) |-> (!oe_n && !dq_oe));
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && cas_n && !req_ready));
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RASP(T_RASP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .req_ready(req_ready), .ref_gnt(ref_gnt), .rd_valid(rd_valid)
);

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;
  localparam int T_RCD = 3, T_CAS = 2, T_CP = 1, T_RP = 5;
  localparam int T_RAS_MIN = 8, T_RC = 14, T_RAC = 8, T_RASP = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, ref_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic [7:0] rd_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [11:0] daddr;
  logic [7:0] dq_out, dq_in;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  edo_page_ctrl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .T_RC(T_RC), .T_RAC(T_RAC), .T_RASP(T_RASP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(daddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // DRAM model: latches row and column on strobe falls, output stays driven after CAS rises
  logic [7:0] mdl_mem [logic [20:0]];
  logic [11:0] m_row = '0, m_col = '0;
  logic [7:0]  m_data = 8'h00;
  logic        m_valid = 1'b0;

  always @(negedge ras_n) m_row = daddr;
  always @(posedge ras_n) m_valid = 1'b0;
  always @(negedge cas_n) begin
    m_col = daddr;
    if (!we_n) begin
      check(dq_oe == 1'b1, "R3 write data driven at CAS fall", int'(dq_oe), 1);
      mdl_mem[{m_row, m_col[8:0]}] = dq_out;
      m_valid = 1'b0;
    end else begin
      m_data  = mdl_mem.exists({m_row, m_col[8:0]}) ? mdl_mem[{m_row, m_col[8:0]}] : 8'h00;
      m_valid = 1'b1;
    end
  end
  assign dq_in = (m_valid && !oe_n) ? m_data : 8'hEE;

  // scoreboard
  logic [7:0] shadow [logic [20:0]];
  logic [7:0] exp_q [$];

  task automatic issue(input logic [20:0] a, input logic we, input logic [7:0] d);
    req_addr = a; req_we = we; req_wdata = d; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (we) shadow[a] = d;
    else exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
  endtask

  // monitor and timing statistics
  int act_cnt = 0, since_fall = 0, lo_run = 0, hi_run = 0, cas_lo_run = 0, cas_hi_run = 0;
  int min_lo = 1000000, max_lo = 0, min_hi = 1000000, min_rc = 1000000;
  int min_cas_lo = 1000000, min_cas_hi = 1000000, min_rcd = 1000000, min_rac = 1000000;
  bit prev_ras = 1'b1, prev_cas = 1'b1, seen_rise = 1'b0, seen_fall = 1'b0, cas_in_row = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (!ras_n && prev_ras) begin
      act_cnt++;
      if (seen_fall && since_fall < min_rc) min_rc = since_fall;
      if (seen_rise && hi_run < min_hi) min_hi = hi_run;
      seen_fall = 1'b1; since_fall = 0; lo_run = 0; cas_in_row = 1'b0;
    end
    if (ras_n && !prev_ras) begin
      seen_rise = 1'b1; hi_run = 0;
      if (lo_run < min_lo) min_lo = lo_run;
      if (lo_run > max_lo) max_lo = lo_run;
    end
    if (!cas_n && prev_cas) begin
      if (!cas_in_row && since_fall < min_rcd) min_rcd = since_fall;
      if (cas_in_row && cas_hi_run < min_cas_hi) min_cas_hi = cas_hi_run;
      cas_in_row = 1'b1; cas_lo_run = 0;
    end
    if (cas_n && !prev_cas) begin
      if (cas_lo_run < min_cas_lo) min_cas_lo = cas_lo_run;
      cas_hi_run = 0;
    end
    if (rd_valid) begin
      if (since_fall < min_rac) min_rac = since_fall;
      if (exp_q.size() == 0) check(1'b0, "R4 unexpected read data", int'(rd_data), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R4 read data", int'(rd_data), int'(e));
      end
    end
    since_fall++;
    if (!ras_n) lo_run++; else hi_run++;
    if (!cas_n) cas_lo_run++; else cas_hi_run++;
    prev_ras = ras_n; prev_cas = cas_n;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0, a1, any_ready;
    repeat (5) @(negedge clk);
    check({ras_n, cas_n, we_n, oe_n} == 4'hF, "R2 strobes high in reset", int'({ras_n, cas_n, we_n, oe_n}), 15);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({dq_oe, req_ready, rd_valid, ref_gnt} == 4'h0, "R2 outputs idle", int'({dq_oe, req_ready, rd_valid, ref_gnt}), 0);
    check({ras_n, cas_n, we_n, oe_n} == 4'hF, "R2 strobes high after reset", int'({ras_n, cas_n, we_n, oe_n}), 15);

    // R5: page hits share one activation
    a0 = act_cnt;
    issue({12'h005, 9'h003}, 1'b1, 8'h11);
    issue({12'h005, 9'h004}, 1'b1, 8'h22);
    issue({12'h005, 9'h003}, 1'b0, 8'h00);
    issue({12'h005, 9'h004}, 1'b0, 8'h00);
    drain();
    check(act_cnt - a0 == 1, "R5 one activation for same row", act_cnt - a0, 1);

    // R6: row miss
    a0 = act_cnt;
    issue({12'h009, 9'h007}, 1'b1, 8'h33);
    issue({12'h005, 9'h003}, 1'b0, 8'h00);
    drain();
    check(act_cnt - a0 == 2, "R6 two activations for row change", act_cnt - a0, 2);

    // R1: address split on the pins
    issue({12'hABC, 9'h1F5}, 1'b1, 8'h5A);
    repeat (4) @(negedge clk);
    check(m_row == 12'hABC, "R1 row on pins", int'(m_row), 'hABC);
    check(m_col == 12'h1F5, "R1 column on pins", int'(m_col), 'h1F5);
    issue({12'hABC, 9'h1F5}, 1'b0, 8'h00);
    drain();

    // R10: refresh pre-emption with a host request waiting
    issue({12'h005, 9'h004}, 1'b0, 8'h00);
    drain();
    ref_req = 1'b1;
    a1 = 0;
    while (!ref_gnt && a1 < 60) begin @(negedge clk); a1++; end
    check(ref_gnt == 1'b1, "R10 grant raised", int'(ref_gnt), 1);
    check(ras_n && cas_n, "R10 row closed during grant", int'({ras_n, cas_n}), 3);
    req_addr = {12'h005, 9'h004}; req_we = 1'b0; req_valid = 1'b1;
    any_ready = 0;
    repeat (10) begin @(negedge clk); #1; if (req_ready) any_ready++; end
    check(any_ready == 0, "R10 host held off while granted", any_ready, 0);
    ref_req = 1'b0;
    issue({12'h005, 9'h004}, 1'b0, 8'h00);
    check(ref_gnt == 1'b0, "R10 grant released", int'(ref_gnt), 0);
    drain();

    // R8: stream of same-row reads must be cut by the RAS-low limit
    a0 = act_cnt;
    for (int i = 0; i < 30; i++) issue({12'h005, 9'(i)}, 1'b0, 8'h00);
    drain();
    check(act_cnt - a0 >= 2, "R8 row reopened during long stream", act_cnt - a0, 2);

    // R3: assorted writes across rows, read back in reverse
    for (int i = 0; i < 8; i++) issue({12'(i * 37 + 1), 9'(i * 91)}, 1'b1, 8'(i * 29 + 7));
    for (int i = 7; i >= 0; i--) issue({12'(i * 37 + 1), 9'(i * 91)}, 1'b0, 8'h00);
    drain();

    repeat (60) @(negedge clk);
    check(min_lo >= T_RAS_MIN, "R7 minimum RAS low", min_lo, T_RAS_MIN);
    check(min_hi >= T_RP, "R7 minimum RAS precharge", min_hi, T_RP);
    check(min_rc >= T_RC, "R7 minimum RAS cycle", min_rc, T_RC);
    check(max_lo <= T_RASP, "R8 maximum RAS low", max_lo, T_RASP);
    check(min_rcd >= T_RCD, "R9 RAS to CAS delay", min_rcd, T_RCD);
    check(min_cas_lo >= T_CAS, "R9 minimum CAS low", min_cas_lo, T_CAS);
    check(min_cas_hi >= T_CP, "R9 minimum CAS high", min_cas_hi, T_CP);
    check(min_rac >= T_RAC, "R11 read sample after RAS access time", min_rac, T_RAC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule